// File: doc/BRIEF.md
# Twisted-Pair Transceiver Receive and Status Control

This block is the digital control core of a 10 Mb/s twisted-pair attachment unit. It runs from a 10 MHz clock and sits between the station and the analog line front end. It decides when receive data reaches the station: either after the squelch front end reports a qualified line signal, or through an internal loopback of the station's own transmit stream. It also gates transmit data towards the line driver. Alongside this it raises a collision/status flag, a jabber flag and a link-fail LED output.

Four state machines do the work. The receive path FSM has the states `RX_IDLE`, `RX_QUAL`, `RX_TAIL` and `RX_LOOP`. Its transitions are: idle to qual on a qualified line, idle/qual/tail to loop when loopback is selected, qual to tail when qualification drops, tail back to qual on requalification, tail to idle once the tail count expires, and loop to idle when loopback is released. The jabber FSM moves `JB_CLEAR` to `JB_HOLD` when a transmit run is over-long, and back to `JB_CLEAR` after a quiet time. The test-pulse FSM moves `SQ_IDLE` to `SQ_PULSE` on a falling edge of the test select (a new falling edge restarts the pulse), and back to `SQ_IDLE` when the pulse length is used up. The link FSM moves `LK_FAIL` to `LK_RECV` on a qualified line, `LK_RECV` to `LK_GOOD` when qualification ends, `LK_GOOD` back to `LK_RECV` when it returns, and `LK_GOOD` to `LK_FAIL` after a silent period.

In loopback the line driver gets no station data. Instead the block requests one-clock link test pulses at a fixed period.

Top module: `tp_xcvr_ctrl`

## Requirements
- R1: While reset is asserted: rx_en=0, rx_data=1, col_stat=0 (with idle inputs), jab_stat=0, link_fail_led=1, drv_en=0, drv_data=0, ltp_req=0.
- R2: With loop_sel_n=1, a clock edge that samples sq_ok=1 enables reception from that edge on: rx_en=1, and rx_data follows sq_data combinationally.
- R3: Whenever rx_en=0, rx_data=1.
- R4: After an edge samples sq_ok=0 in the qualified state, rx_en stays high for TAIL_CLKS more edges (default 2, i.e. 200 ns) and then falls, unless sq_ok returns first.
- R5: One edge after loop_sel_n is sampled 0, rx_en equals stn_tx_en and rx_data equals stn_tx_data while stn_tx_en=1. While loop_sel_n=0, drv_en=0. Releasing loopback returns the receive path to idle at the next edge.
- R6: While loop_sel_n=0, ltp_req is a single-clock (100 ns) pulse every LTP_PERIOD edges. ltp_req is never high one edge after loop_sel_n was sampled 1.
- R7: With fdx_sel_n=1 and loop_sel_n=1, stn_tx_en=1 together with sq_ok=1 drives col_stat=1 in the same cycle.
- R8: With fdx_sel_n=0, simultaneous transmit and receive does not raise col_stat.
- R9: After JAB_LIMIT consecutive edges sample stn_tx_en=1, jab_stat=1 and col_stat=1. While jab_stat=1, drv_en=0. Otherwise drv_en=stn_tx_en & loop_sel_n, and drv_data=drv_en & stn_tx_data.
- R10: jab_stat clears only after UNJAB_CLKS consecutive edges sample stn_tx_en=0.
- R11: An edge that samples sqe_test_n=0, when the previous edge (or reset) saw 1, drives col_stat high for the next SQE_LEN cycles. drv_en and drv_data are unaffected.
- R12: link_fail_led is 1 after reset and goes to 0 one edge after sq_ok is sampled 1. It returns to 1 after LINK_LOSS consecutive edges without sq_ok.
- R13: While sq_ok stays 1, link_fail_led toggles every BLINK_CLKS edges, starting from 0 (lit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 10 MHz clock |
| rst_n | input | 1 | asynchronous active-low reset |
| stn_tx_en | input | 1 | station transmit enable |
| stn_tx_data | input | 1 | station transmit data |
| sq_ok | input | 1 | squelch reports qualified line signal |
| sq_data | input | 1 | recovered line data |
| loop_sel_n | input | 1 | loopback select, active low |
| fdx_sel_n | input | 1 | full-duplex select, active low |
| sqe_test_n | input | 1 | status test select, active low, edge started |
| rx_en | output | 1 | receive enable to station |
| rx_data | output | 1 | gated receive data |
| col_stat | output | 1 | collision / jabber / test status flag |
| jab_stat | output | 1 | jabber flag |
| link_fail_led | output | 1 | link-fail LED, low = lit |
| drv_en | output | 1 | line driver data enable |
| drv_data | output | 1 | line driver data |
| ltp_req | output | 1 | link test pulse request |

## Verification
A receive FSM stuck in the wrong state shows up within one clock: rx_en or rx_data disagrees with the squelch input or with the looped transmit stream, or the two-clock tail is too short or too long. A wrong jabber or test-pulse counter moves the edge of jab_stat, drv_en or col_stat by a cycle or more, and the bench catches this at the exact cycle. Link FSM faults show as a missing or mistimed LED toggle within one blink period, or as a wrong return to the fail state after the silent period.

// File: rtl/tp_xcvr_pkg.sv
package tp_xcvr_pkg;
    typedef enum logic [1:0] {RX_IDLE, RX_QUAL, RX_TAIL, RX_LOOP} rx_state_t;
    typedef enum logic {JB_CLEAR, JB_HOLD} jab_state_t;
    typedef enum logic {SQ_IDLE, SQ_PULSE} sqe_state_t;
    typedef enum logic [1:0] {LK_FAIL, LK_GOOD, LK_RECV} link_state_t;
endpackage

// File: rtl/tp_rx_path.sv
module tp_rx_path
    import tp_xcvr_pkg::*;
#(
    parameter int TAIL_CLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic loop_act,
    input  logic sq_ok,
    input  logic sq_data,
    input  logic tx_en,
    input  logic tx_data,
    output logic rx_en,
    output logic rx_data
);
    localparam int CW = $clog2(TAIL_CLKS + 1);

    rx_state_t       state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            RX_IDLE: begin
                if (loop_act)   state_d = RX_LOOP;
                else if (sq_ok) state_d = RX_QUAL;
            end
            RX_QUAL: begin
                if (loop_act) state_d = RX_LOOP;
                else if (!sq_ok) begin
                    state_d = RX_TAIL;
                    cnt_d   = '0;
                end
            end
            RX_TAIL: begin
                if (loop_act)                          state_d = RX_LOOP;
                else if (sq_ok)                        state_d = RX_QUAL;
                else if (cnt_q == CW'(TAIL_CLKS - 1))  state_d = RX_IDLE;
                else                                   cnt_d = cnt_q + 1'b1;
            end
            RX_LOOP: begin
                if (!loop_act) state_d = RX_IDLE;
            end
            default: state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        rx_en   = 1'b0;
        rx_data = 1'b1;
        unique case (state_q)
            RX_QUAL, RX_TAIL: begin
                rx_en   = 1'b1;
                rx_data = sq_data;
            end
            RX_LOOP: begin
                rx_en   = tx_en;
                rx_data = tx_en ? tx_data : 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/tp_jabber.sv
module tp_jabber
    import tp_xcvr_pkg::*;
#(
    parameter int JAB_LIMIT  = 500000,
    parameter int UNJAB_CLKS = 5000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    output logic jab
);
    localparam int MAXC = (JAB_LIMIT > UNJAB_CLKS) ? JAB_LIMIT : UNJAB_CLKS;
    localparam int CW   = $clog2(MAXC + 1);

    jab_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            JB_CLEAR: begin
                if (!tx_en) cnt_d = '0;
                else if (cnt_q == CW'(JAB_LIMIT - 1)) begin
                    state_d = JB_HOLD;
                    cnt_d   = '0;
                end else cnt_d = cnt_q + 1'b1;
            end
            JB_HOLD: begin
                if (tx_en) cnt_d = '0;
                else if (cnt_q == CW'(UNJAB_CLKS - 1)) begin
                    state_d = JB_CLEAR;
                    cnt_d   = '0;
                end else cnt_d = cnt_q + 1'b1;
            end
            default: state_d = JB_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= JB_CLEAR;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb jab = (state_q == JB_HOLD);
endmodule

// File: rtl/tp_status.sv
module tp_status
    import tp_xcvr_pkg::*;
#(
    parameter int SQE_LEN = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sqe_test_n,
    input  logic tx_en,
    input  logic sq_ok,
    input  logic loop_act,
    input  logic fdx_act,
    input  logic jab,
    output logic col_stat
);
    localparam int CW = $clog2(SQE_LEN + 1);

    sqe_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          sel_prev_q;
    logic          start;
    logic          collide;

    always_comb start = sel_prev_q && !sqe_test_n;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SQ_IDLE: begin
                if (start) begin
                    state_d = SQ_PULSE;
                    cnt_d   = '0;
                end
            end
            SQ_PULSE: begin
                if (start)                             cnt_d = '0;
                else if (cnt_q == CW'(SQE_LEN - 1))    state_d = SQ_IDLE;
                else                                   cnt_d = cnt_q + 1'b1;
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= SQ_IDLE;
            cnt_q      <= '0;
            sel_prev_q <= 1'b1;
        end else begin
            state_q    <= state_d;
            cnt_q      <= cnt_d;
            sel_prev_q <= sqe_test_n;
        end
    end

    always_comb begin
        collide  = tx_en && sq_ok && !fdx_act && !loop_act;
        col_stat = jab || collide || (state_q == SQ_PULSE);
    end
endmodule

// File: rtl/tp_link.sv
module tp_link
    import tp_xcvr_pkg::*;
#(
    parameter int BLINK_CLKS = 1000000,
    parameter int LINK_LOSS  = 1500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sq_ok,
    output logic link_fail
);
    localparam int MAXC = (BLINK_CLKS > LINK_LOSS) ? BLINK_CLKS : LINK_LOSS;
    localparam int CW   = $clog2(MAXC + 1);

    link_state_t   state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          phase_q, phase_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        phase_d = phase_q;
        unique case (state_q)
            LK_FAIL: begin
                if (sq_ok) begin
                    state_d = LK_RECV;
                    cnt_d   = '0;
                    phase_d = 1'b0;
                end
            end
            LK_GOOD: begin
                if (sq_ok) begin
                    state_d = LK_RECV;
                    cnt_d   = '0;
                    phase_d = 1'b0;
                end else if (cnt_q == CW'(LINK_LOSS - 1)) begin
                    state_d = LK_FAIL;
                    cnt_d   = '0;
                end else cnt_d = cnt_q + 1'b1;
            end
            LK_RECV: begin
                if (!sq_ok) begin
                    state_d = LK_GOOD;
                    cnt_d   = '0;
                    phase_d = 1'b0;
                end else if (cnt_q == CW'(BLINK_CLKS - 1)) begin
                    cnt_d   = '0;
                    phase_d = !phase_q;
                end else cnt_d = cnt_q + 1'b1;
            end
            default: state_d = LK_FAIL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LK_FAIL;
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            phase_q <= phase_d;
        end
    end

    always_comb begin
        unique case (state_q)
            LK_FAIL: link_fail = 1'b1;
            LK_RECV: link_fail = phase_q;
            default: link_fail = 1'b0;
        endcase
    end
endmodule

// File: rtl/tp_xcvr_ctrl.sv
module tp_xcvr_ctrl #(
    parameter int TAIL_CLKS   = 2,
    parameter int JAB_LIMIT   = 500000,
    parameter int UNJAB_CLKS  = 5000000,
    parameter int SQE_LEN     = 10,
    parameter int BLINK_CLKS  = 1000000,
    parameter int LINK_LOSS   = 1500000,
    parameter int LTP_PERIOD  = 160000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stn_tx_en,
    input  logic stn_tx_data,
    input  logic sq_ok,
    input  logic sq_data,
    input  logic loop_sel_n,
    input  logic fdx_sel_n,
    input  logic sqe_test_n,
    output logic rx_en,
    output logic rx_data,
    output logic col_stat,
    output logic jab_stat,
    output logic link_fail_led,
    output logic drv_en,
    output logic drv_data,
    output logic ltp_req
);
    localparam int PW = $clog2(LTP_PERIOD + 1);

    logic          loop_act;
    logic          fdx_act;
    logic          jab;
    logic [PW-1:0] ltp_cnt_q;
    logic          ltp_q;

    always_comb begin
        loop_act = !loop_sel_n;
        fdx_act  = !fdx_sel_n;
    end

    tp_rx_path #(.TAIL_CLKS(TAIL_CLKS)) u_rx (
        .clk(clk), .rst_n(rst_n), .loop_act(loop_act), .sq_ok(sq_ok),
        .sq_data(sq_data), .tx_en(stn_tx_en), .tx_data(stn_tx_data),
        .rx_en(rx_en), .rx_data(rx_data)
    );

    tp_jabber #(.JAB_LIMIT(JAB_LIMIT), .UNJAB_CLKS(UNJAB_CLKS)) u_jab (
        .clk(clk), .rst_n(rst_n), .tx_en(stn_tx_en), .jab(jab)
    );

    tp_status #(.SQE_LEN(SQE_LEN)) u_stat (
        .clk(clk), .rst_n(rst_n), .sqe_test_n(sqe_test_n), .tx_en(stn_tx_en),
        .sq_ok(sq_ok), .loop_act(loop_act), .fdx_act(fdx_act), .jab(jab),
        .col_stat(col_stat)
    );

    tp_link #(.BLINK_CLKS(BLINK_CLKS), .LINK_LOSS(LINK_LOSS)) u_link (
        .clk(clk), .rst_n(rst_n), .sq_ok(sq_ok), .link_fail(link_fail_led)
    );

    // Link test pulse timer, running only in loopback.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ltp_cnt_q <= '0;
            ltp_q     <= 1'b0;
        end else if (!loop_act) begin
            ltp_cnt_q <= '0;
            ltp_q     <= 1'b0;
        end else if (ltp_cnt_q == PW'(LTP_PERIOD - 1)) begin
            ltp_cnt_q <= '0;
            ltp_q     <= 1'b1;
        end else begin
            ltp_cnt_q <= ltp_cnt_q + 1'b1;
            ltp_q     <= 1'b0;
        end
    end

    always_comb begin
        jab_stat = jab;
        ltp_req  = ltp_q;
        drv_en   = stn_tx_en && !loop_act && !jab;
        drv_data = drv_en && stn_tx_data;
    end
endmodule

// File: rtl/tp_xcvr_ctrl_chk.sv
module tp_xcvr_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic stn_tx_en,
    input logic sq_ok,
    input logic loop_sel_n,
    input logic fdx_sel_n,
    input logic sqe_test_n,
    input logic rx_en,
    input logic rx_data,
    input logic col_stat,
    input logic jab_stat,
    input logic drv_en,
    input logic ltp_req
);
    // R3
    idle_data_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |-> rx_data);

    // R2
    qual_enables_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sq_ok) && $past(loop_sel_n) && $past(loop_sel_n, 2)) |-> rx_en);

    // R6
    ltp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ltp_req |=> !ltp_req);

    // R6
    ltp_only_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ltp_req |-> $past(!loop_sel_n));

    // R7
    collision_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stn_tx_en && sq_ok && fdx_sel_n && loop_sel_n) |-> col_stat);

    // R9
    jab_blocks_drv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jab_stat |-> !drv_en);

    // R10
    unjab_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(jab_stat) |-> $past(!stn_tx_en));

    // R11
    sqe_pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(sqe_test_n)) |=> col_stat);
endmodule

bind tp_xcvr_ctrl tp_xcvr_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .stn_tx_en(stn_tx_en), .sq_ok(sq_ok),
    .loop_sel_n(loop_sel_n), .fdx_sel_n(fdx_sel_n), .sqe_test_n(sqe_test_n),
    .rx_en(rx_en), .rx_data(rx_data), .col_stat(col_stat), .jab_stat(jab_stat),
    .drv_en(drv_en), .ltp_req(ltp_req)
);

// File: tb/tp_xcvr_ctrl_bench.sv
`timescale 1ns/1ps
module tp_xcvr_ctrl_bench;
    localparam int TAIL = 2, JLIM = 40, UNJ = 20, SQL = 6, BLK = 16, LOSS = 50, LTP = 12;

    logic clk = 1'b0, rst_n = 1'b0;
    logic tx_en = 0, tx_d = 0, sq = 0, sqd = 0, loop_n = 1, fdx_n = 1, sqe_n = 1;
    logic rx_en, rx_data, col, jab, lnk, drv_en, drv_d, ltp;
    int checks = 0, errors = 0;

    // reference state
    int rs = 0, rc = 0, js = 0, jc = 0, son = 0, sc = 0, sprev = 1;
    int ls = 0, lc = 0, lph = 0, pc = 0, pq = 0;

    always #2.5 clk = ~clk;

    tp_xcvr_ctrl #(.TAIL_CLKS(TAIL), .JAB_LIMIT(JLIM), .UNJAB_CLKS(UNJ), .SQE_LEN(SQL),
                   .BLINK_CLKS(BLK), .LINK_LOSS(LOSS), .LTP_PERIOD(LTP)) u_tp_xcvr_ctrl (
        .clk(clk), .rst_n(rst_n), .stn_tx_en(tx_en), .stn_tx_data(tx_d), .sq_ok(sq),
        .sq_data(sqd), .loop_sel_n(loop_n), .fdx_sel_n(fdx_n), .sqe_test_n(sqe_n),
        .rx_en(rx_en), .rx_data(rx_data), .col_stat(col), .jab_stat(jab),
        .link_fail_led(lnk), .drv_en(drv_en), .drv_data(drv_d), .ltp_req(ltp));

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic e_rx_en();
        return (rs == 1 || rs == 2) || (rs == 3 && tx_en);
    endfunction
    function automatic logic e_rx_data();
        if (rs == 1 || rs == 2) return sqd;
        if (rs == 3 && tx_en) return tx_d;
        return 1'b1;
    endfunction
    function automatic logic e_col();
        return (js == 1) || (son == 1) || (tx_en && sq && fdx_n && loop_n);
    endfunction
    function automatic logic e_drv();
        return tx_en && loop_n && (js == 0);
    endfunction
    function automatic logic e_lnk();
        if (ls == 0) return 1'b1;
        if (ls == 2) return lph[0];
        return 1'b0;
    endfunction

    task automatic compare_all();
        chk("R2 R4 R5 rx_en", rx_en, e_rx_en());
        chk("R3 R5 rx_data", rx_data, e_rx_data());
        chk("R7 R8 R11 col_stat", col, e_col());
        chk("R9 R10 jab_stat", jab, js == 1);
        chk("R12 R13 link_fail", lnk, e_lnk());
        chk("R5 R9 drv_en", drv_en, e_drv());
        chk("R9 drv_data", drv_d, e_drv() && tx_d);
        chk("R6 ltp_req", ltp, pq == 1);
    endtask

    // advance the reference by one sampled edge
    task automatic model_edge();
        bit lp = !loop_n;
        case (rs)
            0: if (lp) rs = 3; else if (sq) rs = 1;
            1: if (lp) rs = 3; else if (!sq) begin rs = 2; rc = 0; end
            2: if (lp) rs = 3; else if (sq) rs = 1; else if (rc == TAIL - 1) rs = 0; else rc++;
            default: if (!lp) rs = 0;
        endcase
        if (js == 0) begin
            if (!tx_en) jc = 0; else if (jc == JLIM - 1) begin js = 1; jc = 0; end else jc++;
        end else begin
            if (tx_en) jc = 0; else if (jc == UNJ - 1) begin js = 0; jc = 0; end else jc++;
        end
        if (sprev == 1 && !sqe_n) begin son = 1; sc = 0; end
        else if (son == 1) begin if (sc == SQL - 1) son = 0; else sc++; end
        sprev = sqe_n;
        case (ls)
            0: if (sq) begin ls = 2; lc = 0; lph = 0; end
            1: if (sq) begin ls = 2; lc = 0; lph = 0; end
               else if (lc == LOSS - 1) begin ls = 0; lc = 0; end else lc++;
            default: if (!sq) begin ls = 1; lc = 0; lph = 0; end
                     else if (lc == BLK - 1) begin lc = 0; lph ^= 1; end else lc++;
        endcase
        if (!lp) begin pc = 0; pq = 0; end
        else if (pc == LTP - 1) begin pc = 0; pq = 1; end
        else begin pc++; pq = 0; end
    endtask

    task automatic step();
        @(posedge clk);
        #1 model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 rx_en", rx_en, 1'b0);
        chk("R1 rx_data", rx_data, 1'b1);
        chk("R1 col_stat", col, 1'b0);
        chk("R1 jab_stat", jab, 1'b0);
        chk("R1 link_fail", lnk, 1'b1);
        chk("R1 drv_en", drv_en, 1'b0);
        chk("R1 ltp_req", ltp, 1'b0);
        rst_n = 1'b1;

        // directed: qualify, tail of 2 clocks (R2, R4)
        sq = 1; sqd = 0; step();
        chk("R2 directed rx_en", rx_en, 1'b1);
        chk("R2 directed rx_data", rx_data, 1'b0);
        sq = 0; step();
        chk("R4 tail 1", rx_en, 1'b1);
        step();
        chk("R4 tail 2", rx_en, 1'b1);
        step();
        chk("R4 tail end", rx_en, 1'b0);
        chk("R3 forced high", rx_data, 1'b1);

        // directed: jabber after JLIM edges, unjab after UNJ quiet edges (R9, R10)
        tx_en = 1;
        for (int i = 0; i < JLIM - 1; i++) step();
        chk("R9 not yet", jab, 1'b0);
        step();
        chk("R9 jab set", jab, 1'b1);
        chk("R9 drv blocked", drv_en, 1'b0);
        tx_en = 0;
        for (int i = 0; i < UNJ - 1; i++) step();
        chk("R10 still jab", jab, 1'b1);
        step();
        chk("R10 cleared", jab, 1'b0);

        // directed: test pulse during transmit leaves driver alone (R11)
        tx_en = 1; tx_d = 1; sqe_n = 0; step();
        chk("R11 pulse on", col, 1'b1);
        chk("R11 drv untouched", drv_d, 1'b1);
        tx_en = 0; sqe_n = 1;
        for (int i = 0; i < SQL; i++) step();
        chk("R11 pulse off", col, 1'b0);

        // directed: full duplex suppresses collision (R8)
        fdx_n = 0; tx_en = 1; sq = 1; step();
        chk("R8 no collision", col, 1'b0);
        fdx_n = 1; step();
        chk("R7 collision", col, 1'b1);
        tx_en = 0; sq = 0;
        for (int i = 0; i < 4; i++) step();

        // directed: loopback path (R5, R6)
        loop_n = 0; tx_en = 1; tx_d = 0; step();
        chk("R5 loop rx_en", rx_en, 1'b1);
        chk("R5 loop rx_data", rx_data, 1'b0);
        chk("R5 loop drv off", drv_en, 1'b0);
        tx_en = 0;
        for (int i = 0; i < 2 * LTP; i++) step();
        loop_n = 1; step();

        // constrained random phase
        for (int n = 0; n < 20000; n++) begin
            if ($urandom_range(29, 0) == 0) tx_en = !tx_en;
            if ($urandom_range(19, 0) == 0) sq = !sq;
            if ($urandom_range(199, 0) == 0) loop_n = !loop_n;
            if ($urandom_range(149, 0) == 0) fdx_n = !fdx_n;
            if ($urandom_range(24, 0) == 0) sqe_n = !sqe_n;
            tx_d = 1'($urandom);
            sqd  = 1'($urandom);
            step();
        end
        finish_run();
    end
endmodule